// File: doc/BRIEF.md
# Control-Register Window Decoder

This block sits between a 32-bit register bus and ten peripheral register banks in a chip's control-register region. Each incoming read or write has its address reduced to 29 bits. Bits 28:16 of that address pick a bank, and bits 7:2 pick a register slot inside the bank. Every bank has a highest legal offset. The first bank is asymmetric: it accepts reads at higher offsets than it accepts writes. Accesses beyond a bank's limit, and accesses to selectors that map to nothing, return zero on a read, are dropped on a write, and raise a one-cycle error flag.

Each slot carries an access attribute that is fixed at elaboration from a parameter table. A slot can refuse access entirely. It can be read-only. It can be plain local storage. Or it can be handed to the owning peripheral through per-bank read and write strobes, for reads, for writes, or for both. Two selectors that address write-only DRAM mode regions absorb writes silently and read as zero without an error. Read data, the read-valid flag and the error flag are registered. Peripheral strobes are combinational in the access cycle, and the peripheral answers a forwarded read in that same cycle.

Top module: `regwin_decoder`

## Requirements
- R1: Bits 31:29 of the address are ignored. Bits 28:16 select the bank. Bank index and strobe bit: 0=0x1F00, 1=0x1F20, 2=0x1F80, 3=0x1FA0, 4=0x1FC0, 5=0x1FC8, 6=0x1FD0, 7=0x1FD8, 8=0x1FE0, 9=0x1FE8.
- R2: The slot index is address bits 7:2. Address bits 1:0 have no effect.
- R3: Highest legal low-16-bit offset per bank index: 1:0x20, 2:0x48, 3:0x40, 4:0x10, 5:0x3C, 6:0x10, 7:0x2C, 8:0x1C, 9:0x24. A read beyond the limit returns 0 and a write beyond it changes nothing. Either one pulses the error flag.
- R4: Bank 0 accepts reads up to offset 0x44 but writes only up to offset 0x3C.
- R5: A selector that matches no bank and no DRAM mode region reads 0 and pulses the error flag. A write to it changes nothing.
- R6: Selectors 0x1F90 and 0x1F94 read 0 without an error, and writes to them are accepted without an error or a strobe.
- R7: Attribute codes are 0 none, 1 read-only, 2 local storage, 3 forwarded read and write, 4 forwarded read with local write, 5 local read with forwarded write. The default table gives slot s of bank b the code (b+s) mod 6.
- R8: A slot with code 0 reads 0 and ignores writes. A slot with code 1 ignores writes and reads its stored value, which stays 0.
- R9: All stored values reset to 0. A local write is returned by a later local read of the same slot.
- R10: A forwarded read raises exactly one read strobe, bit b, in the access cycle, with the slot on the slot port. The peripheral's word for bank b becomes the read data.
- R11: A forwarded write raises exactly one write strobe in the access cycle, with the slot and data on the forward ports. The slot's local value does not change.
- R12: Read data and read-valid appear one cycle after the request. The error flag is a one-cycle pulse in that same cycle.
- R13: When read and write are requested together, only the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 32 | Access address |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read request, one cycle |
| bus_wr_i | input | 1 | Write request, one cycle |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Registered read-valid |
| bus_err_o | output | 1 | One-cycle error pulse for an out-of-range or unmapped access |
| fwd_rd_o | output | 10 | Per-bank forwarded read strobe |
| fwd_wr_o | output | 10 | Per-bank forwarded write strobe |
| fwd_slot_o | output | 5 | Slot index of the forwarded access |
| fwd_wdata_o | output | 32 | Forwarded write data |
| fwd_rdata_i | input | 320 | Per-bank peripheral read data, bank b in bits 32b+31:32b |

## Verification
The bench goes after the exact limit offsets and the offset one word beyond each limit. Using the read limit on writes would let a bank-0 write at 0x40 land in storage, and an off-by-one compare would flag the last legal slot or accept the next one. It also drives combined read-and-write requests, the DRAM mode selectors, unaligned and high-bit-polluted addresses, and slots of every attribute code. A decoder that mixed up attributes would forward a local slot, store into a forwarded or read-only slot, or strobe the wrong bank. One that let writes through on a combined request would corrupt the storage that later reads return.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int ADDR_W    = 32;
    localparam int MASK_W    = 29;
    localparam int OFF_W     = 16;
    localparam int SEL_W     = MASK_W - OFF_W;
    localparam int NUM_BANKS = 10;
    localparam int SLOTS     = 19;
    localparam int ATTR_W    = 3;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int BIDX_W    = $clog2(NUM_BANKS);
    localparam int MAP_W     = NUM_BANKS * SLOTS * ATTR_W;

    localparam logic [SEL_W-1:0] DRAM_SEL_A = 13'h1F90;
    localparam logic [SEL_W-1:0] DRAM_SEL_B = 13'h1F94;

    typedef enum logic [ATTR_W-1:0] {
        ATTR_NONE   = 3'd0,
        ATTR_RO     = 3'd1,
        ATTR_RW     = 3'd2,
        ATTR_FWD    = 3'd3,
        ATTR_FWD_RD = 3'd4,
        ATTR_FWD_WR = 3'd5
    } slot_attr_e;

    function automatic logic [SEL_W-1:0] bank_sel(input int b);
        case (b)
            0: return 13'h1F00;
            1: return 13'h1F20;
            2: return 13'h1F80;
            3: return 13'h1FA0;
            4: return 13'h1FC0;
            5: return 13'h1FC8;
            6: return 13'h1FD0;
            7: return 13'h1FD8;
            8: return 13'h1FE0;
            9: return 13'h1FE8;
            default: return '1;
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] bank_rd_lim(input int b);
        case (b)
            0: return 16'h0044;
            1: return 16'h0020;
            2: return 16'h0048;
            3: return 16'h0040;
            4: return 16'h0010;
            5: return 16'h003C;
            6: return 16'h0010;
            7: return 16'h002C;
            8: return 16'h001C;
            9: return 16'h0024;
            default: return '0;
        endcase
    endfunction

    // Bank 0 is the only bank whose write limit is lower than its read limit.
    function automatic logic [OFF_W-1:0] bank_wr_lim(input int b);
        return (b == 0) ? 16'h003C : bank_rd_lim(b);
    endfunction

    function automatic logic [MAP_W-1:0] default_attr_map();
        logic [MAP_W-1:0] m;
        m = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int s = 0; s < SLOTS; s++) begin
                m[(b*SLOTS + s)*ATTR_W +: ATTR_W] = ATTR_W'((b + s) % 6);
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/regwin_addr_decode.sv
module regwin_addr_decode
    import regwin_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr_i,
    output logic                 hit_o,
    output logic                 dram_o,
    output logic [NUM_BANKS-1:0] bank_oh_o,
    output logic [BIDX_W-1:0]    bank_idx_o,
    output logic                 rd_ok_o,
    output logic                 wr_ok_o,
    output logic [SLOT_W-1:0]    slot_o
);
    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] rd_lim;
    logic [OFF_W-1:0] wr_lim;
    logic             unused_hi;

    assign sel       = addr_i[MASK_W-1:OFF_W];
    assign off       = addr_i[OFF_W-1:0];
    assign slot_o    = off[SLOT_W+1:2];
    assign unused_hi = ^addr_i[ADDR_W-1:MASK_W];

    always_comb begin
        hit_o      = 1'b0;
        bank_oh_o  = '0;
        bank_idx_o = '0;
        rd_lim     = '0;
        wr_lim     = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel == bank_sel(b)) begin
                hit_o        = 1'b1;
                bank_oh_o[b] = 1'b1;
                bank_idx_o   = BIDX_W'(b);
                rd_lim       = bank_rd_lim(b);
                wr_lim       = bank_wr_lim(b);
            end
        end
    end

    assign dram_o  = (sel == DRAM_SEL_A) || (sel == DRAM_SEL_B);
    assign rd_ok_o = hit_o && (off <= rd_lim);
    assign wr_ok_o = hit_o && (off <= wr_lim);
endmodule

// File: rtl/regwin_attr_lookup.sv
module regwin_attr_lookup
    import regwin_pkg::*;
#(
    parameter logic [MAP_W-1:0] ATTR_MAP = default_attr_map()
) (
    input  logic [BIDX_W-1:0] bank_i,
    input  logic [SLOT_W-1:0] slot_i,
    output slot_attr_e        attr_o
);
    always_comb begin
        attr_o = ATTR_NONE;
        if ((int'(slot_i) < SLOTS) && (int'(bank_i) < NUM_BANKS)) begin
            attr_o = slot_attr_e'(ATTR_MAP[(int'(bank_i)*SLOTS + int'(slot_i))*ATTR_W +: ATTR_W]);
        end
    end
endmodule

// File: rtl/regwin_slot_store.sv
module regwin_slot_store
    import regwin_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_d [SLOTS];
    logic [DATA_W-1:0] mem_q [SLOTS];

    always_comb begin
        mem_d = mem_q;
        if (we_i && (int'(idx_i) < SLOTS)) begin
            mem_d[idx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) mem_q[s] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = (int'(idx_i) < SLOTS) ? mem_q[idx_i] : '0;
endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
    import regwin_pkg::*;
#(
    parameter int               DATA_W   = 32,
    parameter logic [MAP_W-1:0] ATTR_MAP = default_attr_map()
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic [DATA_W-1:0]           bus_wdata_i,
    input  logic                        bus_rd_i,
    input  logic                        bus_wr_i,
    output logic [DATA_W-1:0]           bus_rdata_o,
    output logic                        bus_rvalid_o,
    output logic                        bus_err_o,
    output logic [NUM_BANKS-1:0]        fwd_rd_o,
    output logic [NUM_BANKS-1:0]        fwd_wr_o,
    output logic [SLOT_W-1:0]           fwd_slot_o,
    output logic [DATA_W-1:0]           fwd_wdata_o,
    input  logic [NUM_BANKS*DATA_W-1:0] fwd_rdata_i
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              err;
    } resp_t;

    resp_t rsp_d, rsp_q;

    logic                 dec_hit, dec_dram, dec_rd_ok, dec_wr_ok;
    logic [NUM_BANKS-1:0] dec_oh;
    logic [BIDX_W-1:0]    dec_idx;
    logic [SLOT_W-1:0]    dec_slot;
    slot_attr_e           attr;
    logic [NUM_BANKS-1:0] local_we;
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];
    logic [DATA_W-1:0]    local_rdata;
    logic [DATA_W-1:0]    periph_rdata;
    logic                 rd_req, wr_req;

    regwin_addr_decode u_dec (
        .addr_i     (bus_addr_i),
        .hit_o      (dec_hit),
        .dram_o     (dec_dram),
        .bank_oh_o  (dec_oh),
        .bank_idx_o (dec_idx),
        .rd_ok_o    (dec_rd_ok),
        .wr_ok_o    (dec_wr_ok),
        .slot_o     (dec_slot)
    );

    regwin_attr_lookup #(.ATTR_MAP(ATTR_MAP)) u_attr (
        .bank_i (dec_idx),
        .slot_i (dec_slot),
        .attr_o (attr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        regwin_slot_store #(.DATA_W(DATA_W)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (local_we[b]),
            .idx_i   (dec_slot),
            .wdata_i (bus_wdata_i),
            .rdata_o (bank_rdata[b])
        );
    end

    always_comb begin
        local_rdata  = '0;
        periph_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec_oh[b]) begin
                local_rdata  = bank_rdata[b];
                periph_rdata = fwd_rdata_i[b*DATA_W +: DATA_W];
            end
        end
    end

    // Read wins when both requests arrive together; the write is dropped.
    assign rd_req = bus_rd_i;
    assign wr_req = bus_wr_i && !bus_rd_i;

    always_comb begin
        rsp_d        = '0;
        rsp_d.rvalid = rd_req;
        fwd_rd_o     = '0;
        fwd_wr_o     = '0;
        local_we     = '0;
        if (rd_req && !dec_dram) begin
            if (!dec_rd_ok) begin
                rsp_d.err = 1'b1;
            end else begin
                case (attr)
                    ATTR_RO, ATTR_RW, ATTR_FWD_WR: rsp_d.rdata = local_rdata;
                    ATTR_FWD, ATTR_FWD_RD: begin
                        rsp_d.rdata = periph_rdata;
                        fwd_rd_o    = dec_oh;
                    end
                    default: rsp_d.rdata = '0;
                endcase
            end
        end else if (wr_req && !dec_dram) begin
            if (!dec_wr_ok) begin
                rsp_d.err = 1'b1;
            end else begin
                case (attr)
                    ATTR_RW, ATTR_FWD_RD:  local_we = dec_oh;
                    ATTR_FWD, ATTR_FWD_WR: fwd_wr_o = dec_oh;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_rdata_o  = rsp_q.rdata;
    assign bus_rvalid_o = rsp_q.rvalid;
    assign bus_err_o    = rsp_q.err;
    assign fwd_slot_o   = dec_slot;
    assign fwd_wdata_o  = bus_wdata_i;
endmodule

// File: rtl/regwin_decoder_chk.sv
module regwin_decoder_chk
    import regwin_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic                 bus_rd_i,
    input logic                 bus_wr_i,
    input logic [DATA_W-1:0]    bus_rdata_o,
    input logic                 bus_rvalid_o,
    input logic                 bus_err_o,
    input logic [NUM_BANKS-1:0] fwd_rd_o,
    input logic [NUM_BANKS-1:0] fwd_wr_o
);
    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] off;
    assign sel = bus_addr_i[MASK_W-1:OFF_W];
    assign off = bus_addr_i[OFF_W-1:0];

    assert_rvalid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_i |=> bus_rvalid_o);
    assert_rvalid_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> !bus_rvalid_o);
    assert_err_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> $past(bus_rd_i || bus_wr_i));
    assert_rd_strobe_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fwd_rd_o) && (fwd_rd_o == '0 || bus_rd_i));
    assert_wr_strobe_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fwd_wr_o) && (fwd_wr_o == '0 || (bus_wr_i && !bus_rd_i)));
    assert_rd_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_wr_i) |-> (fwd_wr_o == '0));
    assert_dram_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && (sel == DRAM_SEL_A || sel == DRAM_SEL_B)) |=> (bus_rdata_o == '0 && !bus_err_o));
    assert_bank0_wr_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !bus_rd_i && sel == 13'h1F00 && off > 16'h003C) |=> bus_err_o);
    assert_over_limit_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && sel == 13'h1F20 && off > 16'h0020) |=> (bus_err_o && bus_rdata_o == '0));
endmodule

bind regwin_decoder regwin_decoder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr_i   (bus_addr_i),
    .bus_rd_i     (bus_rd_i),
    .bus_wr_i     (bus_wr_i),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .bus_err_o    (bus_err_o),
    .fwd_rd_o     (fwd_rd_o),
    .fwd_wr_o     (fwd_wr_o)
);

// File: tb/regwin_decoder_tb.sv
module regwin_decoder_tb;
    localparam int NB = 10;
    localparam int NS = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic          bus_err;
    logic [NB-1:0] fwd_rd;
    logic [NB-1:0] fwd_wr;
    logic [4:0]    fwd_slot;
    logic [31:0]   fwd_wdata;
    logic [NB*32-1:0] fwd_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] model [NB][NS];

    always #10 clk = ~clk;

    for (genvar b = 0; b < NB; b++) begin : g_periph
        assign fwd_rdata[b*32 +: 32] = 32'hA500_0000 | (32'(b) << 16) | 32'(fwd_slot);
    end

    regwin_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_rdata_o(bus_rdata),
        .bus_rvalid_o(bus_rvalid), .bus_err_o(bus_err), .fwd_rd_o(fwd_rd),
        .fwd_wr_o(fwd_wr), .fwd_slot_o(fwd_slot), .fwd_wdata_o(fwd_wdata),
        .fwd_rdata_i(fwd_rdata)
    );

    function automatic logic [12:0] tb_sel(input int b);
        case (b)
            0: return 13'h1F00; 1: return 13'h1F20; 2: return 13'h1F80; 3: return 13'h1FA0;
            4: return 13'h1FC0; 5: return 13'h1FC8; 6: return 13'h1FD0; 7: return 13'h1FD8;
            8: return 13'h1FE0; default: return 13'h1FE8;
        endcase
    endfunction

    function automatic int tb_rlim(input int b);
        case (b)
            0: return 'h44; 1: return 'h20; 2: return 'h48; 3: return 'h40; 4: return 'h10;
            5: return 'h3C; 6: return 'h10; 7: return 'h2C; 8: return 'h1C; default: return 'h24;
        endcase
    endfunction

    function automatic int tb_wlim(input int b);
        return (b == 0) ? 'h3C : tb_rlim(b);
    endfunction

    // -1 unmapped, -2 DRAM mode region, otherwise bank index
    function automatic int tb_bank(input logic [31:0] a);
        for (int b = 0; b < NB; b++) if (a[28:16] == tb_sel(b)) return b;
        if (a[28:16] == 13'h1F90 || a[28:16] == 13'h1F94) return -2;
        return -1;
    endfunction

    function automatic logic [31:0] periph(input int b, input int s);
        return 32'hA500_0000 | (32'(b) << 16) | 32'(s);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic wr, input logic [31:0] a,
                          input logic [31:0] d, input string req);
        int b, s, off, attr;
        logic rd_e, wr_e, e_err, do_store;
        logic [31:0] e_rdata;
        logic [NB-1:0] e_frd, e_fwr;
        b = tb_bank(a);
        off = int'(a[15:0]);
        s = int'(a[7:2]);
        rd_e = rd;
        wr_e = wr && !rd;
        e_err = 1'b0; e_rdata = '0; e_frd = '0; e_fwr = '0; do_store = 1'b0;
        if (b == -1) begin
            e_err = rd_e || wr_e;
        end else if (b >= 0) begin
            if (rd_e) begin
                if (off > tb_rlim(b)) e_err = 1'b1;
                else begin
                    attr = (b + s) % 6;
                    if (attr == 1 || attr == 2 || attr == 5) e_rdata = model[b][s];
                    else if (attr == 3 || attr == 4) begin
                        e_rdata = periph(b, s);
                        e_frd[b] = 1'b1;
                    end
                end
            end else if (wr_e) begin
                if (off > tb_wlim(b)) e_err = 1'b1;
                else begin
                    attr = (b + s) % 6;
                    if (attr == 2 || attr == 4) do_store = 1'b1;
                    else if (attr == 3 || attr == 5) e_fwr[b] = 1'b1;
                end
            end
        end
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #2;
        check(fwd_rd == e_frd, {req, " read strobe R10"}, 32'(fwd_rd), 32'(e_frd));
        check(fwd_wr == e_fwr, {req, " write strobe R11"}, 32'(fwd_wr), 32'(e_fwr));
        if (e_frd != '0 || e_fwr != '0)
            check(int'(fwd_slot) == s, {req, " forward slot R2"}, 32'(fwd_slot), 32'(s));
        if (e_fwr != '0)
            check(fwd_wdata == d, {req, " forward data R11"}, fwd_wdata, d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        check(bus_rvalid == rd, {req, " rvalid R12"}, 32'(bus_rvalid), 32'(rd));
        check(bus_err == e_err, {req, " error R12"}, 32'(bus_err), 32'(e_err));
        if (rd) check(bus_rdata == e_rdata, {req, " rdata"}, bus_rdata, e_rdata);
        if (do_store) model[b][s] = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired R12 actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        for (int b = 0; b < NB; b++) for (int s = 0; s < NS; s++) model[b][s] = '0;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_rvalid == 1'b0 && bus_err == 1'b0, "reset outputs R12", {30'd0, bus_rvalid, bus_err}, 32'd0);
        check(bus_rdata == '0, "reset rdata R9", bus_rdata, 32'd0);

        // R9 local storage, R1 high address bits ignored
        access(1'b0, 1'b1, 32'hFF00_0008, 32'h1234_5678, "R9 write rw slot");
        access(1'b1, 1'b0, 32'h1F00_0008, 32'h0, "R1 read masked alias");
        access(1'b1, 1'b0, 32'hBF00_000B, 32'h0, "R2 unaligned read");
        // R8 none and read-only slots
        access(1'b0, 1'b1, 32'hFF00_0000, 32'hDEAD_BEEF, "R8 write none slot");
        access(1'b1, 1'b0, 32'hFF00_0000, 32'h0, "R8 read none slot");
        access(1'b0, 1'b1, 32'hFF00_0004, 32'hCAFE_F00D, "R8 write ro slot");
        access(1'b1, 1'b0, 32'hFF00_0004, 32'h0, "R8 read ro slot");
        // R11 forwarded write leaves local value untouched (slot 5 reads locally)
        access(1'b0, 1'b1, 32'hFF00_0014, 32'h5555_AAAA, "R11 fwd write");
        access(1'b1, 1'b0, 32'hFF00_0014, 32'h0, "R11 local read after fwd write");
        // R10 forwarded read on the last bank, R7 mapping
        access(1'b1, 1'b0, 32'hFFE8_0000, 32'h0, "R10 fwd read bank 9");
        access(1'b1, 1'b0, 32'hFF20_0008, 32'h0, "R7 fwd read bank 1 slot 2");
        // R4 bank 0 asymmetric limit
        access(1'b0, 1'b1, 32'hFF00_0040, 32'h0BAD_0BAD, "R4 write beyond write limit");
        access(1'b1, 1'b0, 32'hFF00_0040, 32'h0, "R4 read within read limit");
        access(1'b1, 1'b0, 32'hFF00_0044, 32'h0, "R4 read at read limit");
        access(1'b1, 1'b0, 32'hFF00_0048, 32'h0, "R4 read beyond read limit");
        access(1'b0, 1'b1, 32'hFF00_003C, 32'h7777_0000, "R4 write at write limit");
        // R3 limits
        access(1'b0, 1'b1, 32'hFF80_0048, 32'h4848_4848, "R3 write at limit bank 2");
        access(1'b1, 1'b0, 32'hFF80_0048, 32'h0, "R3 read at limit bank 2");
        access(1'b1, 1'b0, 32'hFF80_004C, 32'h0, "R3 read beyond limit bank 2");
        access(1'b1, 1'b0, 32'hFF20_0024, 32'h0, "R3 read beyond limit bank 1");
        access(1'b0, 1'b1, 32'hFF20_0100, 32'h1, "R3 write high offset");
        // R5 unmapped, R6 DRAM mode regions
        access(1'b1, 1'b0, 32'hFF10_0000, 32'h0, "R5 unmapped read");
        access(1'b0, 1'b1, 32'hFF10_0000, 32'h2, "R5 unmapped write");
        access(1'b1, 1'b0, 32'hFF90_0000, 32'h0, "R6 dram read");
        access(1'b0, 1'b1, 32'hFF94_0010, 32'h3, "R6 dram write");
        // R13 read wins on combined request
        access(1'b1, 1'b1, 32'hFF00_0008, 32'hFFFF_0000, "R13 combined request");
        access(1'b1, 1'b0, 32'hFF00_0008, 32'h0, "R13 value unchanged");

        for (int i = 0; i < 3000; i++) begin
            int k, bsel, sl;
            logic [31:0] a;
            logic rd, wr;
            logic [12:0] sel;
            k = int'($urandom_range(0, 19));
            bsel = int'($urandom_range(0, NB - 1));
            sel = tb_sel(bsel);
            if (k == 0) sel = 13'($urandom);
            else if (k == 1) sel = ($urandom_range(0, 1) == 0) ? 13'h1F90 : 13'h1F94;
            sl = int'($urandom_range(0, 23));
            a = {3'($urandom), sel, 8'h00, 6'(sl), 2'($urandom_range(0, 3))};
            if (k == 2) a[15:8] = 8'($urandom_range(1, 255));
            rd = 1'($urandom);
            wr = ($urandom_range(0, 7) == 0) ? 1'b1 : !rd;
            access(rd, wr, a, $urandom, "random R7");
        end
        finish_run();
    end
endmodule